// File: doc/BRIEF.md
# I2C Paged Serial Memory Target

This block is the memory side of a small board-maintenance device. It listens on an I2C bus, whose clock and data have already been brought into the system clock domain, and serves a 256-byte store that is modelled as a register array. The bus controller writes to the store through a 16-byte page buffer. It reads the store through a single internal address counter. That counter serves current-address reads, random reads (a write carrying only a word address, then a repeated start) and sequential reads.

Each write transaction collects its data bytes in the page buffer. The stop condition commits the buffer to the array and starts a busy interval whose length, in system clock cycles, is a parameter. While the block is busy it refuses its bus address. A neighbouring port expander can watch the busy flag to learn that memory is locked. A write-control input, held high, blocks the commit.

Top module: `i2c_page_store`

## Requirements
- R1: The target answers only to the address byte whose bits, most significant first, are 1, the six strap inputs from strap_i[5] down to strap_i[0], and then the direction bit (0 = write, 1 = read). It acknowledges by pulling SDA low in the ninth clock. A byte with a different strap value, or with a leading 0, is not acknowledged.
- R2: In a write, the first byte after the address is the word address and every later byte is data. The target acknowledges each of them. A single data byte followed by a stop is stored at the word address.
- R3: After each data byte only the low four bits of the address counter advance. A 17th byte in one transaction lands on the first byte's location and overwrites it. Locations outside the page are left unchanged.
- R4: A stop that follows at least one data byte, with wr_ctl_i low, raises busy_o for exactly BUSY_CYCLES system clock cycles.
- R5: While busy_o is high, the memory address byte is not acknowledged, and the store is unchanged by the refused transaction.
- R6: A stop that follows only a word address loads the address counter and raises no busy interval.
- R7: After any access, the counter holds the location after the last byte accessed. A current-address read returns the byte at that location.
- R8: A random read returns the byte at the word address sent in the preceding write phase.
- R9: A sequential read continues while the controller acknowledges each byte. It advances the full 8-bit counter and wraps from 255 to 0.
- R10: A read byte that the controller does not acknowledge ends the transfer. The target releases SDA and ignores further clocks until the next start.
- R11: With wr_ctl_i high at the stop, nothing is committed and busy_o stays low.
- R12: After reset, SDA is released, busy_o is low, the counter is 0 and every location reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock |
| sda_i | input | 1 | Synchronized bus data (wired line level) |
| sda_pull_o | output | 1 | 1 pulls the SDA line low |
| strap_i | input | 6 | Address strap bits |
| wr_ctl_i | input | 1 | Write control; high blocks the commit |
| busy_o | output | 1 | Commit interval in progress |

## Verification
The hardest state to reach from the ports is an address byte that arrives while a commit interval is still running. The bench builds the block with a long busy interval. It then issues a fresh start and address directly after a committing stop, so the address byte is complete before the interval ends. A second hard case is a page write long enough to wrap. The bench sends eighteen bytes that start two below a page boundary. It then reads both the overwritten locations and the neighbouring page to confirm that the wrap stays inside the page.

// File: rtl/pm_pkg.sv
// Package: shared types for the paged serial memory target.
// Assumes byte-wide bus transfers; all other sizes come from module parameters.
package pm_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } pm_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_WADDR,
        PH_DATA
    } pm_phase_e;
endpackage

// File: rtl/pm_bus_events.sv
// Module: pm_bus_events
// Turns the synchronized bus lines into single-cycle events: start, stop,
// clock rise and clock fall. Assumes scl_i/sda_i are already synchronous
// to clk and free of glitches.
module pm_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_q;
    logic sda_q;

    // Keep the previous line levels; idle bus is high on both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Classify the edges seen between the previous and current levels.
    always_comb begin
        start_o = scl_q && scl_i && sda_q && !sda_i;
        stop_o  = scl_q && scl_i && !sda_q && sda_i;
        rise_o  = !scl_q && scl_i;
        fall_o  = scl_q && !scl_i;
    end
endmodule

// File: rtl/pm_store.sv
// Module: pm_store
// Holds the register-array store, the page buffer and the commit timer.
// Assumes the buffer is cleared (with its page base) before data arrives,
// and that commit_i never coincides with buf_we_i or buf_clr_i.
module pm_store #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 4,
    parameter int BUSY_CYCLES = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        rd_addr_i,
    output logic [DATA_W-1:0]        rd_data_o,
    input  logic                     buf_clr_i,
    input  logic [ADDR_W-PAGE_W-1:0] page_base_i,
    input  logic                     buf_we_i,
    input  logic [PAGE_W-1:0]        buf_idx_i,
    input  logic [DATA_W-1:0]        buf_data_i,
    input  logic                     commit_i,
    output logic                     busy_o
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PAGE_N = 1 << PAGE_W;
    localparam int CNT_W  = $clog2(BUSY_CYCLES + 1);

    logic [DATA_W-1:0]        mem_q [DEPTH];
    logic [DATA_W-1:0]        pg_q  [PAGE_N];
    logic [PAGE_N-1:0]        vld_q;
    logic [ADDR_W-PAGE_W-1:0] base_q;
    logic                     busy_q;
    logic [CNT_W-1:0]         cnt_q;

    // Page buffer: collect data bytes and remember which slots were written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            base_q <= '0;
            for (int i = 0; i < PAGE_N; i++) pg_q[i] <= '0;
        end else if (buf_clr_i) begin
            vld_q  <= '0;
            base_q <= page_base_i;
        end else if (commit_i) begin
            vld_q <= '0;
        end else if (buf_we_i) begin
            pg_q[buf_idx_i]  <= buf_data_i;
            vld_q[buf_idx_i] <= 1'b1;
        end
    end

    // Store array: cleared at reset, written from valid buffer slots on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (commit_i) begin
            for (int i = 0; i < PAGE_N; i++) begin
                if (vld_q[i]) mem_q[{base_q, PAGE_W'(i)}] <= pg_q[i];
            end
        end
    end

    // Read port: the byte addressed by the counter.
    assign rd_data_o = mem_q[rd_addr_i];

    // Commit timer: busy for exactly BUSY_CYCLES cycles after a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (commit_i) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(BUSY_CYCLES - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy_o = busy_q;

    // R4: the timer is never re-armed while an interval runs.
    a_r4_no_commit_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !commit_i);
    // R4: the interval cannot end before the count is spent.
    a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0) |=> busy_q);
    // R3: buffer writes and commits never overlap.
    a_r3_no_write_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> !buf_we_i);
endmodule

// File: rtl/pm_target_fsm.sv
// Module: pm_target_fsm
// Byte-level I2C target sequencer: address match, word-address load,
// data collection, read transmit and controller-acknowledge handling.
// Owns the address counter. Assumes single-cycle bus events from
// pm_bus_events and a combinational read port on the store.
module pm_target_fsm
    import pm_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int PAGE_W  = 4,
    parameter int STRAP_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     stop_i,
    input  logic                     rise_i,
    input  logic                     fall_i,
    input  logic                     sda_i,
    input  logic [STRAP_W-1:0]       strap_i,
    input  logic                     wr_ctl_i,
    input  logic                     busy_i,
    input  logic [BYTE_W-1:0]        rd_data_i,
    output logic                     sda_pull_o,
    output logic [ADDR_W-1:0]        addr_o,
    output logic                     buf_clr_o,
    output logic [ADDR_W-PAGE_W-1:0] page_base_o,
    output logic                     buf_we_o,
    output logic [PAGE_W-1:0]        buf_idx_o,
    output logic [BYTE_W-1:0]        buf_data_o,
    output logic                     commit_o
);
    localparam logic [3:0] RX_LAST = 4'd8;
    localparam logic [3:0] TX_LAST = 4'd7;

    pm_state_e          state_q;
    pm_phase_e          phase_q;
    logic [BYTE_W-1:0]  shift_q;
    logic [3:0]         bcnt_q;
    logic               rw_q;
    logic               mack_q;
    logic               data_seen_q;
    logic [ADDR_W-1:0]  ctr_q;
    logic               rx_done;
    logic               byte_ack;
    logic               addr_match;

    // Decode the end of a received byte and whether it earns an acknowledge.
    always_comb begin
        rx_done    = (state_q == ST_RX) && fall_i && (bcnt_q == RX_LAST);
        addr_match = shift_q[BYTE_W-1] && (shift_q[STRAP_W:1] == strap_i);
        byte_ack   = (phase_q == PH_ADDR) ? (addr_match && !busy_i) : 1'b1;
    end

    // Sequencer and address counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            phase_q     <= PH_ADDR;
            shift_q     <= '0;
            bcnt_q      <= '0;
            rw_q        <= 1'b0;
            mack_q      <= 1'b0;
            data_seen_q <= 1'b0;
            ctr_q       <= '0;
        end else if (start_i) begin
            state_q     <= ST_RX;
            phase_q     <= PH_ADDR;
            bcnt_q      <= '0;
            data_seen_q <= 1'b0;
        end else if (stop_i) begin
            state_q     <= ST_IDLE;
            data_seen_q <= 1'b0;
        end else begin
            case (state_q)
                ST_RX: begin
                    if (rise_i && bcnt_q != RX_LAST) begin
                        shift_q <= {shift_q[BYTE_W-2:0], sda_i};
                        bcnt_q  <= bcnt_q + 1'b1;
                    end else if (rx_done) begin
                        state_q <= byte_ack ? ST_ACK : ST_IDLE;
                        case (phase_q)
                            PH_ADDR:  rw_q  <= shift_q[0];
                            PH_WADDR: ctr_q <= shift_q[ADDR_W-1:0];
                            default: begin
                                ctr_q <= {ctr_q[ADDR_W-1:PAGE_W],
                                          ctr_q[PAGE_W-1:0] + PAGE_W'(1)};
                                data_seen_q <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (fall_i) begin
                        bcnt_q <= '0;
                        if (phase_q == PH_ADDR && rw_q) begin
                            state_q <= ST_TX;
                            shift_q <= rd_data_i;
                        end else begin
                            state_q <= ST_RX;
                            phase_q <= (phase_q == PH_ADDR) ? PH_WADDR : PH_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (fall_i) begin
                        if (bcnt_q == TX_LAST) begin
                            state_q <= ST_MACK;
                            ctr_q   <= ctr_q + 1'b1;
                        end else begin
                            bcnt_q  <= bcnt_q + 1'b1;
                            shift_q <= {shift_q[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_MACK: begin
                    if (rise_i) begin
                        mack_q <= !sda_i;
                    end else if (fall_i) begin
                        if (mack_q) begin
                            state_q <= ST_TX;
                            shift_q <= rd_data_i;
                            bcnt_q  <= '0;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Drive the line: acknowledge slot, or a transmitted zero bit.
    assign sda_pull_o = (state_q == ST_ACK) || (state_q == ST_TX && !shift_q[BYTE_W-1]);

    // Buffer and commit strobes toward the store.
    always_comb begin
        buf_clr_o   = rx_done && (phase_q == PH_WADDR);
        page_base_o = shift_q[ADDR_W-1:PAGE_W];
        buf_we_o    = rx_done && (phase_q == PH_DATA);
        buf_idx_o   = ctr_q[PAGE_W-1:0];
        buf_data_o  = shift_q;
        commit_o    = stop_i && data_seen_q && !wr_ctl_i;
    end

    assign addr_o = ctr_q;

    // R3: a data byte never moves the counter out of its page.
    a_r3_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we_o |=> (ctr_q[ADDR_W-1:PAGE_W] == $past(ctr_q[ADDR_W-1:PAGE_W])));
    // R5: no address acknowledge slot while the store is busy.
    a_r5_no_addr_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK && phase_q == PH_ADDR) |-> !busy_i);
    // R6: a commit needs at least one data byte in this transaction.
    a_r6_commit_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (phase_q == PH_DATA));
endmodule

// File: rtl/i2c_page_store.sv
// Module: i2c_page_store (top)
// I2C target front end for a paged register-array store with a timed
// commit interval. Assumes scl_i/sda_i are synchronized to clk and that
// sda_i carries the wired line level including this block's own pull.
module i2c_page_store #(
    parameter int ADDR_W      = 8,
    parameter int PAGE_W      = 4,
    parameter int STRAP_W     = 6,
    parameter int BUSY_CYCLES = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               wr_ctl_i,
    output logic               busy_o
);
    localparam int DATA_W = pm_pkg::BYTE_W;

    logic                     start_evt;
    logic                     stop_evt;
    logic                     rise_evt;
    logic                     fall_evt;
    logic [ADDR_W-1:0]        rd_addr;
    logic [DATA_W-1:0]        rd_data;
    logic                     buf_clr;
    logic [ADDR_W-PAGE_W-1:0] page_base;
    logic                     buf_we;
    logic [PAGE_W-1:0]        buf_idx;
    logic [DATA_W-1:0]        buf_data;
    logic                     commit;

    pm_bus_events i_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .start_o (start_evt),
        .stop_o  (stop_evt),
        .rise_o  (rise_evt),
        .fall_o  (fall_evt)
    );

    pm_target_fsm #(
        .ADDR_W  (ADDR_W),
        .PAGE_W  (PAGE_W),
        .STRAP_W (STRAP_W)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_evt),
        .stop_i      (stop_evt),
        .rise_i      (rise_evt),
        .fall_i      (fall_evt),
        .sda_i       (sda_i),
        .strap_i     (strap_i),
        .wr_ctl_i    (wr_ctl_i),
        .busy_i      (busy_o),
        .rd_data_i   (rd_data),
        .sda_pull_o  (sda_pull_o),
        .addr_o      (rd_addr),
        .buf_clr_o   (buf_clr),
        .page_base_o (page_base),
        .buf_we_o    (buf_we),
        .buf_idx_o   (buf_idx),
        .buf_data_o  (buf_data),
        .commit_o    (commit)
    );

    pm_store #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .PAGE_W      (PAGE_W),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) i_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .buf_clr_i   (buf_clr),
        .page_base_i (page_base),
        .buf_we_i    (buf_we),
        .buf_idx_i   (buf_idx),
        .buf_data_i  (buf_data),
        .commit_i    (commit),
        .busy_o      (busy_o)
    );

    // R12: coming out of reset the line is released and the store idle.
    a_r12_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (!sda_pull_o && !busy_o));
    // R4: a busy interval only begins on a stop condition.
    a_r4_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_evt));
    // R10: the target never changes its drive while the bus clock stays high.
    a_r10_hold_while_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_pull_o));
endmodule

// File: tb/test_i2c_page_store.sv
// Bench: bit-level bus controller model driving i2c_page_store.
module test_i2c_page_store;
    localparam int          Q     = 4;
    localparam int          BUSY  = 400;
    localparam logic [5:0]  STRAP = 6'b101101;
    localparam logic [7:0]  AW    = {1'b1, STRAP, 1'b0};
    localparam logic [7:0]  AR    = {1'b1, STRAP, 1'b1};
    // Table: {word address, data} written by byte write, then read back.
    localparam logic [15:0] VEC [8] = '{16'h00A5, 16'h013C, 16'h7F81, 16'h807E,
                                        16'hFE11, 16'hFFEE, 16'h405A, 16'h41C3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wr_ctl = 1'b0;
    logic sda_pull;
    logic busy;
    logic sda_line;
    int   checks = 0;
    int   fails = 0;
    int   run_len = 0;
    int   last_busy = 0;
    int   busy_pulses = 0;
    logic busy_prev = 1'b0;
    bit   done = 1'b0;

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    i2c_page_store #(.BUSY_CYCLES(BUSY)) i_i2c_page_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .strap_i    (STRAP),
        .wr_ctl_i   (wr_ctl),
        .busy_o     (busy)
    );

    // Measure busy pulses at the port.
    always @(negedge clk) begin
        if (busy) run_len <= run_len + 1;
        else if (run_len != 0) begin last_busy <= run_len; run_len <= 0; end
        if (busy && !busy_prev) busy_pulses <= busy_pulses + 1;
        busy_prev <= busy;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0;
        end
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q / 2);
        ack = !sda_line; tick(Q / 2); scl = 1'b0;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q); scl = 1'b1; tick(Q / 2);
            b = {b[6:0], sda_line}; tick(Q / 2); scl = 1'b0;
        end
        sda_m = !mack; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) tick(1);
        tick(2);
    endtask

    // Write n bytes d0, d0+1, ... at word address wa; returns AND of all acks.
    task automatic write_bytes(input logic [7:0] wa, input int n, input logic [7:0] d0,
                               output logic all_ack);
        logic a;
        bus_start();
        send_byte(AW, a); all_ack = a;
        send_byte(wa, a); all_ack &= a;
        for (int i = 0; i < n; i++) begin
            send_byte(d0 + 8'(i), a); all_ack &= a;
        end
        bus_stop();
    endtask

    task automatic random_read(input logic [7:0] wa, input logic mack_last,
                               output logic [7:0] d);
        logic a;
        bus_start(); send_byte(AW, a); send_byte(wa, a);
        bus_start(); send_byte(AR, a);
        recv_byte(mack_last, d);
    endtask

    task automatic current_read(output logic [7:0] d);
        logic a;
        bus_start(); send_byte(AR, a); recv_byte(1'b0, d); bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic       ok;
        logic       a;
        logic [7:0] d;
        tick(5); rst_n = 1'b1; tick(3);

        // R12: reset state at the ports.
        check(!sda_pull && !busy, "R12 reset outputs", {sda_pull, busy}, 0);
        current_read(d);
        check(d == 8'h00, "R12 cleared store at counter 0", d, 0);

        // Table walk: R2 byte write, R8 random read back.
        for (int k = 0; k < 8; k++) begin
            write_bytes(VEC[k][15:8], 1, VEC[k][7:0], ok);
            check(ok, "R1 R2 address, word and data acknowledged", ok, 1);
            if (k == 0) check(busy, "R4 busy after committing stop", busy, 1);
            wait_idle();
            if (k == 0) check(last_busy == BUSY, "R4 busy length", last_busy, BUSY);
            random_read(VEC[k][15:8], 1'b0, d); bus_stop();
            check(d == VEC[k][7:0], "R8 random read", d, VEC[k][7:0]);
        end

        // R7: current read after a random read of 0x40 gives 0x41.
        random_read(8'h40, 1'b0, d); bus_stop();
        current_read(d);
        check(d == 8'hC3, "R7 current address after read", d, 8'hC3);

        // R9: sequential read wraps 0xFF to 0x00.
        random_read(8'hFE, 1'b1, d);
        check(d == 8'h11, "R9 seq byte FE", d, 8'h11);
        recv_byte(1'b1, d); check(d == 8'hEE, "R9 seq byte FF", d, 8'hEE);
        recv_byte(1'b1, d); check(d == 8'hA5, "R9 seq wrap to 00", d, 8'hA5);
        recv_byte(1'b0, d); check(d == 8'h3C, "R9 seq byte 01", d, 8'h3C);
        bus_stop();

        // R1: wrong strap and leading zero are refused.
        bus_start(); send_byte({1'b1, STRAP ^ 6'b000001, 1'b0}, a); bus_stop();
        check(!a, "R1 wrong strap not acknowledged", a, 0);
        bus_start(); send_byte({1'b0, STRAP, 1'b0}, a); bus_stop();
        check(!a, "R1 leading zero not acknowledged", a, 0);

        // R5: address during the busy interval is refused.
        write_bytes(8'h90, 1, 8'h33, ok);
        bus_start(); send_byte(AW, a); bus_stop();
        check(!a, "R5 address refused while busy", a, 0);
        wait_idle();
        random_read(8'h90, 1'b0, d); bus_stop();
        check(d == 8'h33, "R5 earlier commit intact", d, 8'h33);

        // R3: 18 bytes from 0x2E wrap inside page 0x20..0x2F.
        write_bytes(8'h2E, 18, 8'h10, ok);
        check(ok, "R3 page bytes acknowledged", ok, 1);
        wait_idle();
        current_read(d);
        check(d == 8'h12, "R3 R7 counter wrapped to page start", d, 8'h12);
        random_read(8'h2E, 1'b0, d); bus_stop();
        check(d == 8'h20, "R3 first slot overwritten", d, 8'h20);
        random_read(8'h2D, 1'b0, d); bus_stop();
        check(d == 8'h1F, "R3 last slot in page", d, 8'h1F);
        random_read(8'h30, 1'b0, d); bus_stop();
        check(d == 8'h00, "R3 next page untouched", d, 8'h00);

        // R6: word address only, then stop.
        begin
            int pulses0;
            pulses0 = busy_pulses;
            bus_start(); send_byte(AW, a); send_byte(8'h7F, a); bus_stop();
            tick(20);
            check(busy_pulses == pulses0 && !busy, "R6 no busy after address-only", busy_pulses - pulses0, 0);
            current_read(d);
            check(d == 8'h81, "R6 counter loaded", d, 8'h81);
        end

        // R11: write control high blocks the commit.
        begin
            int pulses0;
            pulses0 = busy_pulses;
            wr_ctl = 1'b1;
            write_bytes(8'h00, 1, 8'h55, ok);
            wr_ctl = 1'b0;
            tick(20);
            check(busy_pulses == pulses0, "R11 no busy with write control high", busy_pulses - pulses0, 0);
            random_read(8'h00, 1'b0, d); bus_stop();
            check(d == 8'hA5, "R11 store unchanged", d, 8'hA5);
        end

        // R10: not-acknowledged byte ends the read; target stays silent.
        begin
            int pulls;
            pulls = 0;
            random_read(8'h80, 1'b0, d);
            check(d == 8'h7E, "R10 byte before end", d, 8'h7E);
            sda_m = 1'b1;
            for (int i = 0; i < 9; i++) begin
                tick(Q); scl = 1'b1; tick(Q / 2);
                if (sda_pull) pulls++;
                tick(Q / 2); scl = 1'b0;
            end
            check(pulls == 0, "R10 released after no-acknowledge", pulls, 0);
            bus_stop();
            current_read(d);
            check(d == 8'h00, "R10 R7 counter past last read", d, 8'h00);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule